// File: doc/BRIEF.md
# Page Write Collector and Program Sequencer

This block sits between a serial-bus protocol controller and a non-volatile memory array. During a write transaction the controller hands it a 9-bit target address and then strobes in data bytes one at a time. The block keeps those bytes in a small page RAM. Each new byte goes to the next slot. When a page holds more than eight bytes, the slot index wraps, and later bytes overwrite the earliest ones. The bytes land in an aligned page of the array, because only the low three address bits advance from byte to byte.

When the controller reports the end of the transaction, the block commits the page, provided at least one byte is held. It then runs a self-timed program cycle. Each occupied slot gets its own interval of `PROG_CYCLES` clocks, and at the start of that interval the block issues one write to the array. While this runs, `busy` is high. The controller uses it to withhold acknowledges. Any new bytes, addresses or commits that arrive during this time are dropped. An abort, or a fresh address load before the commit, throws the collected page away without writing it. A write-protected transaction is handled by never committing it.

Top module: `page_prog_seq`

## Requirements
- R1: After synchronous reset, `busy` and `arr_we` are low and the page is empty.
- R2: With base address B and k the slot index (0 for the first byte held), slot k is written to address {B[8:3], (B[2:0]+k) mod 8}. Bits 8..3 are never changed. Slots are written in ascending order starting from slot 0.
- R3: The (8m+k)-th byte received (counting from 0) is stored in slot k. The slot holds the last such byte. The number of writes N is min(bytes received, 8).
- R4: A commit while the page is empty starts no program cycle. `busy` stays low and no write is issued.
- R5: A commit after exactly one byte produces a single write of that byte to address B.
- R6: `busy` rises in the clock after an accepted commit. It stays high for exactly N·PROG_CYCLES clocks.
- R7: The k-th write shows `arr_we` high for one clock. That clock comes 1 + k·PROG_CYCLES clocks after `busy` rises. The write is always inside the busy window.
- R8: An abort, or an address load, discards all bytes collected before it. When either one coincides with a commit, the discard wins and nothing is written.
- R9: A byte strobe, address load or commit sampled while `busy` is high has no effect. This holds even in the last busy clock. A later commit with no new bytes writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Load target address, starting a new page |
| addr_in | input | ADDR_W | Target address for the first byte |
| byte_stb | input | 1 | One received data byte is valid |
| byte_in | input | DATA_W | Received data byte |
| commit | input | 1 | End of transaction, program the page |
| abort | input | 1 | Discard the page without programming |
| busy | output | 1 | Program cycle in progress |
| arr_we | output | 1 | One-clock array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | DATA_W | Array write data |

## Verification
Two functions can fall in the same clock: discarding the page and committing it. Separately, a new byte can arrive exactly as the program cycle finishes. The bench drives abort together with commit, and also address load followed by fresh bytes. It checks that the write port stays silent or carries only the new page. It also places a byte strobe in the final busy clock, then commits with no new bytes, and judges the result by the absence of any write. The sweep covers one to eleven bytes at several base offsets, including offsets near the top of the page. For each case the expected write addresses, data and clock stamps are computed arithmetically.

// File: rtl/page_prog_pkg.sv
package page_prog_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_PROG = 1'b1
  } seq_state_t;
endpackage

// File: rtl/page_buf.sv
module page_buf #(
  parameter int DATA_W = 8,
  parameter int PAGE   = 8,
  localparam int OFS_W = $clog2(PAGE),
  localparam int CNT_W = $clog2(PAGE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFS_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] mem [0:PAGE-1];
  logic [OFS_W-1:0]  wr_ptr;
  logic [PAGE-1:0]   valid;

  // RAM-style storage: no reset, synchronous read
  always_ff @(posedge clk) begin
    if (wr_en && !clear) mem[wr_ptr] <= wr_data;
    rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      valid  <= '0;
    end else if (wr_en) begin
      wr_ptr        <= wr_ptr + OFS_W'(1);
      valid[wr_ptr] <= 1'b1;
    end
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < PAGE; i++) count = count + CNT_W'(valid[i]);
  end

  // R3: slot index rolls over after the last slot
  a_r3_ptr_wraps: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clear && wr_ptr == OFS_W'(PAGE - 1)) |=> (wr_ptr == '0));
  // R2: a stored byte marks its slot occupied
  a_r2_slot_marked: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clear) |=> valid[$past(wr_ptr)]);
  // R8: a discard empties the page
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count == '0));
endmodule

// File: rtl/page_seq.sv
module page_seq
  import page_prog_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE        = 8,
  parameter int PROG_CYCLES = 125000,
  localparam int OFS_W = $clog2(PAGE),
  localparam int CNT_W = $clog2(PAGE + 1),
  localparam int TMR_W = $clog2(PROG_CYCLES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  n_in,
  input  logic              load_addr,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [OFS_W-1:0]  slot,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr
);
  seq_state_t        state;
  logic [TMR_W-1:0]  timer;
  logic [CNT_W-1:0]  n_q;
  logic [ADDR_W-1:0] base;

  assign busy = (state == SEQ_PROG);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      timer    <= '0;
      slot     <= '0;
      n_q      <= '0;
      base     <= '0;
      arr_we   <= 1'b0;
      arr_addr <= '0;
    end else begin
      arr_we <= 1'b0;
      if (load_addr) base <= addr_in;
      case (state)
        SEQ_IDLE: if (start) begin
          state <= SEQ_PROG;
          slot  <= '0;
          timer <= '0;
          n_q   <= n_in;
        end
        SEQ_PROG: begin
          if (timer == '0) begin
            arr_we   <= 1'b1;
            arr_addr <= {base[ADDR_W-1:OFS_W], base[OFS_W-1:0] + slot};
          end
          if (timer == TMR_W'(PROG_CYCLES - 1)) begin
            timer <= '0;
            if (CNT_W'(slot) == n_q - CNT_W'(1)) state <= SEQ_IDLE;
            else slot <= slot + OFS_W'(1);
          end else begin
            timer <= timer + TMR_W'(1);
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R7: every array write lies inside the busy window
  a_r7_we_in_busy: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);
  // R7: write enable lasts a single clock
  a_r7_we_one_clock: assert property (@(posedge clk) disable iff (rst)
    arr_we |=> !arr_we);
  // R4: a program cycle never starts with an empty page
  a_r4_start_nonempty: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |-> (n_in != '0));
  // R6: busy rises only after a start request
  a_r6_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R3: the slot being programmed stays below the count held
  a_r3_slot_in_range: assert property (@(posedge clk) disable iff (rst)
    busy |-> (CNT_W'(slot) < n_q));
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 9,
  parameter int PAGE        = 8,
  parameter int PROG_CYCLES = 125000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              commit,
  input  logic              abort,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data
);
  localparam int OFS_W = $clog2(PAGE);
  localparam int CNT_W = $clog2(PAGE + 1);

  logic [CNT_W-1:0] count;
  logic [OFS_W-1:0] slot;
  logic go, clear, wr_en, load;

  assign go    = commit && !abort && !addr_load && !busy && (count != '0);
  assign load  = addr_load && !busy;
  assign wr_en = byte_stb && !busy;
  assign clear = abort || load || go;

  page_buf #(.DATA_W(DATA_W), .PAGE(PAGE)) u_buf (
    .clk(clk), .rst(rst), .clear(clear), .wr_en(wr_en), .wr_data(byte_in),
    .rd_idx(slot), .rd_data(arr_data), .count(count)
  );

  page_seq #(.ADDR_W(ADDR_W), .PAGE(PAGE), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start(go), .n_in(count), .load_addr(load),
    .addr_in(addr_in), .slot(slot), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr)
  );

  // R9: nothing is collected while programming
  a_r9_empty_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> (count == '0));
endmodule

// File: tb/page_prog_seq_test.sv
module page_prog_seq_test;
  localparam int P = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic addr_load = 0, byte_stb = 0, commit = 0, abort = 0;
  logic [8:0] addr_in = '0;
  logic [7:0] byte_in = '0;
  logic busy, arr_we;
  logic [8:0] arr_addr;
  logic [7:0] arr_data;

  int checks = 0, failures = 0, cyc = 0, nw = 0, nbusy = 0, c0 = 0;
  logic [8:0] we_a [0:15];
  logic [7:0] we_d [0:15];
  int we_c [0:15];

  page_prog_seq #(.PROG_CYCLES(P)) uut (
    .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
    .byte_stb(byte_stb), .byte_in(byte_in), .commit(commit), .abort(abort),
    .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (arr_we) begin
      if (nw < 16) begin
        we_a[nw] = arr_addr; we_d[nw] = arr_data; we_c[nw] = cyc;
      end
      nw = nw + 1;
    end
    if (busy) nbusy = nbusy + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dval(input int b, input int j);
    return 8'((b * 7 + j * 13 + 1) & 255);
  endfunction

  task automatic clr_mon(); nw = 0; nbusy = 0; endtask
  task automatic p_load(input logic [8:0] a);
    @(negedge clk); addr_load = 1; addr_in = a; @(negedge clk); addr_load = 0;
  endtask
  task automatic p_byte(input logic [7:0] d);
    @(negedge clk); byte_stb = 1; byte_in = d; @(negedge clk); byte_stb = 0;
  endtask
  task automatic p_commit();
    @(negedge clk); commit = 1; c0 = cyc; @(negedge clk); commit = 0;
  endtask
  task automatic wait_idle();
    for (int g = 0; g < 200 && busy; g++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_page(input int b, input int n);
    int nn, j;
    logic [8:0] ea;
    nn = (n > 8) ? 8 : n;
    clr_mon();
    p_load(9'(b));
    for (int i = 0; i < n; i++) p_byte(dval(b, i));
    p_commit();
    wait_idle();
    chk(nw == nn, (n == 1) ? "R5 write count" : "R3 write count", nw, nn);
    chk(nbusy == nn * P, "R6 busy length", nbusy, nn * P);
    for (int k = 0; k < nn && k < 16; k++) begin
      j = k + 8 * ((n - 1 - k) / 8);
      ea = {9'(b) >> 3, 3'(b[2:0] + k)};
      chk(we_a[k] == ea, "R2 address", int'(we_a[k]), int'(ea));
      chk(we_d[k] == dval(b, j), "R3 data", int'(we_d[k]), int'(dval(b, j)));
      chk(we_c[k] == c0 + 2 + k * P, "R7 write timing", we_c[k], c0 + 2 + k * P);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int bases [5] = '{0, 'h105, 'h0FB, 'h1FF, 'h0A3};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(arr_we == 0, "R1 we after reset", arr_we, 0);
    // R4: commit on an empty page
    clr_mon(); p_commit(); repeat (10) @(negedge clk);
    chk(nw == 0, "R4 no write on empty", nw, 0);
    chk(nbusy == 0, "R4 no busy on empty", nbusy, 0);
    // sweep of byte counts and base offsets (R2 R3 R5 R6 R7)
    foreach (bases[bi]) for (int n = 1; n <= 11; n++) run_page(bases[bi], n);
    // R8: abort discards
    clr_mon(); p_load(9'h020); p_byte(8'h11); p_byte(8'h22); p_byte(8'h33);
    @(negedge clk); abort = 1; @(negedge clk); abort = 0;
    p_commit(); wait_idle();
    chk(nw == 0, "R8 abort discards", nw, 0);
    // R8: abort together with commit
    clr_mon(); p_load(9'h030); p_byte(8'h44);
    @(negedge clk); abort = 1; commit = 1; @(negedge clk); abort = 0; commit = 0;
    repeat (10) @(negedge clk);
    chk(nw == 0, "R8 abort beats commit", nw, 0);
    chk(nbusy == 0, "R8 no busy on collision", nbusy, 0);
    p_commit(); wait_idle();
    chk(nw == 0, "R8 page gone after collision", nw, 0);
    // R8: new address load discards earlier bytes
    clr_mon(); p_load(9'h050); p_byte(8'h55); p_byte(8'h66);
    p_load(9'h0C6); p_byte(8'h77); p_commit(); wait_idle();
    chk(nw == 1, "R8 reload count", nw, 1);
    chk(we_a[0] == 9'h0C6, "R8 reload address", int'(we_a[0]), 'h0C6);
    chk(we_d[0] == 8'h77, "R8 reload data", int'(we_d[0]), 'h77);
    // R9: activity during busy is ignored
    clr_mon(); p_load(9'h040); p_byte(8'hA1); p_byte(8'hA2);
    @(negedge clk); commit = 1; c0 = cyc;
    @(negedge clk); commit = 0;
    @(negedge clk); byte_stb = 1; byte_in = 8'hEE;
    @(negedge clk); byte_stb = 0; addr_load = 1; addr_in = 9'h1E0;
    @(negedge clk); addr_load = 0; commit = 1;
    @(negedge clk); commit = 0;
    wait_idle();
    chk(nw == 2, "R9 busy writes count", nw, 2);
    chk(nbusy == 2 * P, "R9 busy not extended", nbusy, 2 * P);
    chk(we_a[1] == 9'h041, "R9 address kept", int'(we_a[1]), 'h041);
    chk(we_d[1] == 8'hA2, "R9 data kept", int'(we_d[1]), 'hA2);
    clr_mon(); p_commit(); wait_idle();
    chk(nw == 0, "R9 strobe while busy dropped", nw, 0);
    // R9: strobe in the final busy clock
    clr_mon(); p_load(9'h010); p_byte(8'h5A);
    @(negedge clk); commit = 1; c0 = cyc;
    @(negedge clk); commit = 0;
    while (cyc < c0 + P) @(negedge clk);
    chk(busy == 1, "R9 last busy clock", busy, 1);
    byte_stb = 1; byte_in = 8'hC3;
    @(negedge clk); byte_stb = 0;
    chk(busy == 0, "R6 busy ends", busy, 0);
    wait_idle();
    clr_mon(); p_commit(); wait_idle();
    chk(nw == 0, "R9 last-clock strobe dropped", nw, 0);
    finish_run();
  end
endmodule